// File: doc/BRIEF.md
# Audio Serial Port Clock Generator

This block makes the three clocks that one direction (receive or transmit) of a multichannel audio serial port needs when the port is the clock master. An integer divider turns the auxiliary reference clock into a high-frequency master clock. A second integer divider turns that master clock into the bit clock. A frame sync generator then counts bit-clock rising edges to produce the frame sync. A device uses one instance for receive and one for transmit, and both instances run from the same reference clock.

The block runs entirely on the reference clock. Each stage passes two things to the next: the level of its clock, and a one-cycle advance pulse. The pulse is high in the reference cycle just before the clock's rising edge. The bit-clock stage can instead take its input from an external master-clock pin, and the frame sync stage from an external bit-clock pin. Each pin is synchronised to the reference clock before it is used.

Each generated signal has its own output enable. When the enable is low, the pad driver is released and the data value to the pad is held at 0. That pin can then act as the input for its stage. Each new setting is held until the stage it belongs to reaches its next terminal count, so a change never produces a runt pulse.

Top module: `aspclk_gen`

## Requirements
- R1: While `rst` is high, each divider whose field is 1 or more holds its output low, and the frame sync holds its inactive level, which is the value of `fs_inv`. During reset, the settings present on the inputs are loaded.
- R2: The master clock is `aux_clk` divided by `mclk_div`+1, so the field values 0 to 255 give ratios 1 to 256. A ratio of 1 passes `aux_clk` straight through.
- R3: With a ratio N of 2 or more, a divider output is high for ceil(N/2) input cycles and low for floor(N/2) input cycles, starting high at each terminal count.
- R4: The bit clock is its source divided by `bclk_div`+1, and a ratio of 1 passes the source level through. `bclk_src_ext`=0 selects the internal master clock. `bclk_src_ext`=1 selects `mclk_pin_i`. A pin rising edge first sampled on reference edge k advances the stage on edge k+2.
- R5: The frame sync generator advances on each rising edge of its source. `fs_src_ext`=0 selects the internal bit clock. `fs_src_ext`=1 selects `bclk_pin_i`, with the same two-edge latency as in R4. The frame length is `frame_len`+1 bits (2 to 512), and a field value of 0 is treated as 1.
- R6: The sync is active on the first bit of each frame. With `fs_word`=0 it lasts one bit. With `fs_word`=1 it lasts floor(L/2) bits for a frame length of L. The active level is 1 when `fs_inv`=0 and 0 when `fs_inv`=1.
- R7: A new divider ratio takes effect only on the input edge that ends the current output period (terminal count). Until then the period in progress keeps the old ratio.
- R8: New values of frame length, mode and polarity take effect only at a frame boundary.
- R9: Each `*_oe` output equals its enable input. While the enable is low, the matching data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aux_clk | input | 1 | Auxiliary reference clock; all logic runs on it |
| rst | input | 1 | Synchronous reset, active high |
| mclk_div | input | DIV_W | Master-clock ratio minus one |
| bclk_div | input | DIV_W | Bit-clock ratio minus one |
| frame_len | input | FLEN_W | Frame length in bits minus one |
| fs_word | input | 1 | 1: sync lasts half a frame; 0: one bit |
| fs_inv | input | 1 | 1: sync active low |
| bclk_src_ext | input | 1 | Bit-clock divider takes its input from the master-clock pin |
| fs_src_ext | input | 1 | Frame sync takes its input from the bit-clock pin |
| mclk_pin_i | input | 1 | Master-clock pin input |
| bclk_pin_i | input | 1 | Bit-clock pin input |
| mclk_en | input | 1 | Drive the master clock onto its pin |
| bclk_en | input | 1 | Drive the bit clock onto its pin |
| fs_en | input | 1 | Drive the frame sync onto its pin |
| mclk_o | output | 1 | Master-clock pin data |
| mclk_oe | output | 1 | Master-clock pin driver enable |
| bclk_o | output | 1 | Bit-clock pin data |
| bclk_oe | output | 1 | Bit-clock pin driver enable |
| fs_o | output | 1 | Frame sync pin data |
| fs_oe | output | 1 | Frame sync pin driver enable |

## Verification
On every cycle, the assertions check four things:
- ratio and frame settings change only at a terminal count or a frame boundary;
- the frame sync moves only on an advance pulse;
- a bit-mode sync is active only on the first bit of a frame;
- a divider output rises only at the start of its period.

The actual ratios, the duty split for odd ratios, the ratio-1 pass-through, the pin synchroniser latency and the output-enable masking are shown only by the bench's scenarios. In these scenarios a behavioural model is compared with the pins on every clock while settings change in mid-period and the sources switch to the external pins.

// File: rtl/aspclk_gen.sv
module aspclk_gen #(
  parameter int DIV_W  = 8,
  parameter int FLEN_W = 9
) (
  input  logic              aux_clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  mclk_div,
  input  logic [DIV_W-1:0]  bclk_div,
  input  logic [FLEN_W-1:0] frame_len,
  input  logic              fs_word,
  input  logic              fs_inv,
  input  logic              bclk_src_ext,
  input  logic              fs_src_ext,
  input  logic              mclk_pin_i,
  input  logic              bclk_pin_i,
  input  logic              mclk_en,
  input  logic              bclk_en,
  input  logic              fs_en,
  output logic              mclk_o,
  output logic              mclk_oe,
  output logic              bclk_o,
  output logic              bclk_oe,
  output logic              fs_o,
  output logic              fs_oe
);

  localparam int DW1 = DIV_W + 1;
  localparam int FW1 = FLEN_W + 1;

  // pin synchronisers: [0],[1] resolve, [2] delays the level to line up with the tick
  logic [2:0] msync, bsync;
  always_ff @(posedge aux_clk) begin
    if (rst) begin
      msync <= '0;
      bsync <= '0;
    end else begin
      msync <= {msync[1:0], mclk_pin_i};
      bsync <= {bsync[1:0], bclk_pin_i};
    end
  end

  logic m_ext_tick, b_ext_tick;
  assign m_ext_tick = msync[1] & ~msync[2];
  assign b_ext_tick = bsync[1] & ~bsync[2];

  // master clock divider: advances on every reference cycle
  logic [DIV_W-1:0] a_act, a_cnt;
  logic             a_q, a_wrap, m_lvl;
  logic [DW1-1:0]   a_hi, a_nxt;

  assign a_wrap = (a_cnt == a_act);
  assign a_hi   = (DW1'(a_act) + DW1'(2)) >> 1;
  assign a_nxt  = DW1'(a_cnt) + DW1'(1);

  always_ff @(posedge aux_clk) begin
    if (rst) begin
      a_act <= mclk_div;
      a_cnt <= mclk_div;
      a_q   <= 1'b0;
    end else if (a_wrap) begin
      a_act <= mclk_div;
      a_cnt <= '0;
      a_q   <= 1'b1;
    end else begin
      a_cnt <= a_cnt + DIV_W'(1);
      a_q   <= (a_nxt < a_hi);
    end
  end

  assign m_lvl = (a_act == '0) ? aux_clk : a_q;

  // bit clock divider
  logic [DIV_W-1:0] b_act, b_cnt;
  logic             b_q, b_tin, b_lin, b_wrap, b_tick, b_lvl;
  logic [DW1-1:0]   b_hi, b_nxt;

  assign b_tin  = bclk_src_ext ? m_ext_tick : a_wrap;
  assign b_lin  = bclk_src_ext ? msync[2]   : m_lvl;
  assign b_wrap = (b_cnt == b_act);
  assign b_tick = b_tin & b_wrap;
  assign b_hi   = (DW1'(b_act) + DW1'(2)) >> 1;
  assign b_nxt  = DW1'(b_cnt) + DW1'(1);

  always_ff @(posedge aux_clk) begin
    if (rst) begin
      b_act <= bclk_div;
      b_cnt <= bclk_div;
      b_q   <= 1'b0;
    end else if (b_tin) begin
      if (b_wrap) begin
        b_act <= bclk_div;
        b_cnt <= '0;
        b_q   <= 1'b1;
      end else begin
        b_cnt <= b_cnt + DIV_W'(1);
        b_q   <= (b_nxt < b_hi);
      end
    end
  end

  assign b_lvl = (b_act == '0) ? b_lin : b_q;

  // frame sync generator
  logic [FLEN_W-1:0] f_req, f_len, f_bc;
  logic              f_tin, f_wrap, act_word, act_inv, f_q;
  logic [FW1-1:0]    f_half, f_nxt;

  assign f_req  = (frame_len == '0) ? FLEN_W'(1) : frame_len;
  assign f_tin  = fs_src_ext ? b_ext_tick : b_tick;
  assign f_wrap = (f_bc == f_len);
  assign f_half = (FW1'(f_len) + FW1'(1)) >> 1;
  assign f_nxt  = FW1'(f_bc) + FW1'(1);

  always_ff @(posedge aux_clk) begin
    if (rst) begin
      f_len    <= f_req;
      f_bc     <= f_req;
      act_word <= fs_word;
      act_inv  <= fs_inv;
      f_q      <= fs_inv;
    end else if (f_tin) begin
      if (f_wrap) begin
        f_len    <= f_req;
        f_bc     <= '0;
        act_word <= fs_word;
        act_inv  <= fs_inv;
        f_q      <= ~fs_inv;
      end else begin
        f_bc <= f_bc + FLEN_W'(1);
        f_q  <= (act_word && (f_nxt < f_half)) ^ act_inv;
      end
    end
  end

  assign mclk_oe = mclk_en;
  assign bclk_oe = bclk_en;
  assign fs_oe   = fs_en;
  assign mclk_o  = mclk_en & m_lvl;
  assign bclk_o  = bclk_en & b_lvl;
  assign fs_o    = fs_en & f_q;

  assert_mclk_ratio_hold_R7: assert property (@(posedge aux_clk) disable iff (rst)
    (!$past(rst) && !$past(a_wrap)) |-> $stable(a_act));

  assert_bclk_ratio_hold_R7: assert property (@(posedge aux_clk) disable iff (rst)
    (!$past(rst) && !$past(b_tick)) |-> $stable(b_act));

  assert_frame_cfg_hold_R8: assert property (@(posedge aux_clk) disable iff (rst)
    (!$past(rst) && !$past(f_tin && f_wrap)) |-> $stable({f_len, act_word, act_inv}));

  assert_fs_moves_on_tick_R5: assert property (@(posedge aux_clk) disable iff (rst)
    (!$past(rst) && !$past(f_tin)) |-> $stable(f_q));

  assert_fs_bit_mode_first_R6: assert property (@(posedge aux_clk) disable iff (rst)
    (!act_word && (f_q != act_inv)) |-> (f_bc == '0));

  assert_mclk_rise_at_start_R3: assert property (@(posedge aux_clk) disable iff (rst)
    ((a_act != '0) && $rose(a_q)) |-> (a_cnt == '0));

endmodule

// File: tb/test_aspclk_gen.sv
module test_aspclk_gen;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] mclk_div, bclk_div;
  logic [8:0] frame_len;
  logic       fs_word, fs_inv, bclk_src_ext, fs_src_ext;
  logic       mclk_pin_i = 1'b0, bclk_pin_i = 1'b0;
  logic       mclk_en, bclk_en, fs_en;
  logic       mclk_o, mclk_oe, bclk_o, bclk_oe, fs_o, fs_oe;

  int    checks = 0, fails = 0;
  bit    done = 0;
  string cur = "R1";

  always #10 clk = ~clk;

  aspclk_gen i_aspclk_gen (
    .aux_clk(clk), .rst(rst), .mclk_div(mclk_div), .bclk_div(bclk_div),
    .frame_len(frame_len), .fs_word(fs_word), .fs_inv(fs_inv),
    .bclk_src_ext(bclk_src_ext), .fs_src_ext(fs_src_ext),
    .mclk_pin_i(mclk_pin_i), .bclk_pin_i(bclk_pin_i),
    .mclk_en(mclk_en), .bclk_en(bclk_en), .fs_en(fs_en),
    .mclk_o(mclk_o), .mclk_oe(mclk_oe), .bclk_o(bclk_o), .bclk_oe(bclk_oe),
    .fs_o(fs_o), .fs_oe(fs_oe));

  task automatic chk(input logic actual, input logic expected, input string what);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", what, actual, expected, $time);
    end
  endtask

  // external pin clocks, slower than the reference
  int mp_n = 0, bp_n = 0;
  always @(negedge clk) begin
    mp_n++; bp_n++;
    if (mp_n == 3) begin mp_n = 0; mclk_pin_i = ~mclk_pin_i; end
    if (bp_n == 5) begin bp_n = 0; bclk_pin_i = ~bclk_pin_i; end
  end

  // behavioural reference model
  int mr, mp, br, bp, flen, fbit;
  bit mq, bq, fword, finv, fq;
  bit ms[3], bs[3];

  task automatic div_step(inout int ratio_m1, inout int phase, inout bit lvl, input int req);
    if (phase == ratio_m1) begin
      ratio_m1 = req; phase = 0; lvl = 1;
    end else begin
      phase++;
      lvl = (phase < (ratio_m1 + 2) / 2);
    end
  endtask

  always @(posedge clk) begin
    bit t_b, t_f, end_m, end_b, mlvl, blin, blvl;
    if (rst) begin
      mr = mclk_div; mp = mr; mq = 0;
      br = bclk_div; bp = br; bq = 0;
      flen = (frame_len == 0) ? 2 : frame_len + 1;
      fbit = flen - 1; fword = fs_word; finv = fs_inv; fq = fs_inv;
      ms = '{0, 0, 0}; bs = '{0, 0, 0};
    end else begin
      end_m = (mp == mr);
      t_b   = bclk_src_ext ? (ms[1] && !ms[2]) : end_m;
      end_b = t_b && (bp == br);
      t_f   = fs_src_ext ? (bs[1] && !bs[2]) : end_b;
      div_step(mr, mp, mq, int'(mclk_div));
      if (t_b) div_step(br, bp, bq, int'(bclk_div));
      if (t_f) begin
        if (fbit == flen - 1) begin
          flen = (frame_len == 0) ? 2 : frame_len + 1;
          fword = fs_word; finv = fs_inv; fbit = 0; fq = !finv;
        end else begin
          fbit++;
          fq = (fword && fbit < flen / 2) ^ finv;
        end
      end
      ms[2] = ms[1]; ms[1] = ms[0]; ms[0] = mclk_pin_i;
      bs[2] = bs[1]; bs[1] = bs[0]; bs[0] = bclk_pin_i;
    end
    #5;
    mlvl = (mr == 0) ? 1'b1 : mq;
    blin = bclk_src_ext ? ms[2] : mlvl;
    blvl = (br == 0) ? blin : bq;
    chk(mclk_o, mclk_en & mlvl, {cur, " / R2 R3 mclk_o"});
    chk(bclk_o, bclk_en & blvl, {cur, " / R4 bclk_o"});
    chk(fs_o, fs_en & fq, {cur, " / R5 R6 fs_o"});
    chk(mclk_oe, mclk_en, {cur, " / R9 mclk_oe"});
    chk(bclk_oe, bclk_en, {cur, " / R9 bclk_oe"});
    chk(fs_oe, fs_en, {cur, " / R9 fs_oe"});
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1; mclk_div = 3; bclk_div = 1; frame_len = 7;
    fs_word = 0; fs_inv = 1; bclk_src_ext = 0; fs_src_ext = 0;
    mclk_en = 1; bclk_en = 1; fs_en = 1;
    cur = "R1 reset";
    run(5);
    chk(mclk_o, 1'b0, "R1 mclk low in reset");
    chk(bclk_o, 1'b0, "R1 bclk low in reset");
    chk(fs_o, 1'b1, "R1 fs inactive (inverted) in reset");
    fs_inv = 0; run(2);
    rst = 0;
    cur = "R2 R3 even ratios"; run(200);
    cur = "R6 word mode";      fs_word = 1; run(300);
    cur = "R2 pass-through";   mclk_div = 0; run(40);
    chk(mclk_o, 1'b0, "R2 pass-through low with aux low");
    @(posedge clk); #5;
    chk(mclk_o, 1'b1, "R2 pass-through high with aux high");
    run(40);
    cur = "R3 odd ratios";     mclk_div = 2; bclk_div = 2; run(300);
    cur = "R7 ratio change";   mclk_div = 6; run(7); bclk_div = 3; run(3); mclk_div = 1; run(300);
    cur = "R8 frame change";   frame_len = 4; run(5); fs_inv = 1; run(5); fs_word = 0; run(300);
    frame_len = 0; run(200);
    cur = "R4 external master"; bclk_src_ext = 1; mclk_en = 0; frame_len = 5; run(300);
    bclk_div = 0; run(100);
    cur = "R5 external bit clock"; fs_src_ext = 1; bclk_en = 0; fs_word = 1; run(300);
    cur = "R9 enables"; fs_en = 0; run(50); mclk_en = 1; bclk_en = 1; fs_en = 1; run(50);
    cur = "R2 R7 max ratio"; bclk_src_ext = 0; fs_src_ext = 0; mclk_div = 255; bclk_div = 0;
    frame_len = 3; run(1500);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule